// File: doc/BRIEF.md
# Sixteen-Bit Reloading Up/Down Timer

This block is a 16-bit counter paired with a 16-bit reload/capture register. It advances on a prescaled tick from elsewhere in the chip (timer source). It can instead advance on falling edges of a count pin, sampled on each tick (counter source). A second pin, the auxiliary pin, is sampled on the same ticks. Depending on the mode, a falling edge on it reloads the counter or captures the counter value. In up/down mode its level sets the count direction instead.

Four modes are chosen from plain control inputs. In reload mode an overflow reloads from the register. Capture mode is a free-running counter whose value is snapped into the register by an auxiliary edge. In up/down mode the direction follows the auxiliary pin and the external flag toggles on every wrap, so that flag can act as a seventeenth count bit. In clock-out mode each overflow reloads and toggles a square-wave output without raising the overflow flag. Software loads the counter and the register through write strobes and clears the two sticky flags through clear strobes. The interrupt request combines the flags.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset the counter, the register, both flags, the interrupt request and the clock output are all 0.
- R2: With `run_i`=1 and `cnt_src_ext_i`=0, each cycle with `tick_i`=1 advances the counter by one. With `cnt_src_ext_i`=1 it advances only on a tick where the count pin reads 0 and read 1 at the previous tick. Both pin samplers start from a stored 0 after reset. With `run_i`=0 the counter holds.
- R3: The mode is selected by priority: `clkout_en_i` first, then `dir_en_i`, then `cap_sel_i`, and reload mode if none is set. In reload mode, a step taken at 0xFFFF loads the register value and sets the overflow flag.
- R4: In reload mode, a falling edge on the auxiliary pin loads the counter from the register and sets the external flag, but only when `ext_en_i`=1. With `ext_en_i`=0 the edge changes nothing.
- R5: In capture mode, an enabled auxiliary falling edge copies the counter into the register and sets the external flag. A step at 0xFFFF wraps to 0x0000 and sets the overflow flag.
- R6: In up/down mode, auxiliary pin level 1 counts up and level 0 counts down. Up at 0xFFFF loads the register value. Down with the counter equal to the register loads 0xFFFF. Both cases set the overflow flag.
- R7: In up/down mode, the external flag toggles on every wrap and never drives the interrupt request. Auxiliary edges neither reload the counter nor set the flag.
- R8: In clock-out mode, a step at 0xFFFF loads the register value and toggles `clk_out_o`, which is low whenever the mode is off. The overflow flag is never set in this mode.
- R9: Both flags stay set until their clear strobe. A set in the same cycle as a clear wins. `irq_o` is the OR of the overflow flag and the external flag, except as stated in R7.
- R10: `wr_cnt_i` overrides any count, reload or wrap in its cycle. `wr_cap_i` overrides a capture in its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled count/sample strobe |
| run_i | input | 1 | Counting enable |
| cnt_src_ext_i | input | 1 | 1 = count pin edges, 0 = ticks |
| ext_en_i | input | 1 | Enables auxiliary-edge reload/capture |
| dir_en_i | input | 1 | Selects up/down mode |
| clkout_en_i | input | 1 | Selects clock-out mode |
| cap_sel_i | input | 1 | Selects capture mode over reload mode |
| cnt_pin_i | input | 1 | External count pin |
| aux_pin_i | input | 1 | Auxiliary pin (edge trigger or direction) |
| wr_cnt_i | input | 1 | Counter write strobe |
| wr_cnt_data_i | input | 16 | Counter write value |
| wr_cap_i | input | 1 | Register write strobe |
| wr_cap_data_i | input | 16 | Register write value |
| tf_clr_i | input | 1 | Overflow flag clear |
| exf_clr_i | input | 1 | External flag clear |
| cnt_o | output | 16 | Counter value |
| cap_o | output | 16 | Reload/capture register value |
| tf_o | output | 1 | Overflow flag |
| exf_o | output | 1 | External flag |
| irq_o | output | 1 | Interrupt request |
| clk_out_o | output | 1 | Square-wave output |

## Verification
The hardest situation to reach is the down-count underflow, because it fires only when the counter equals the register while the auxiliary pin is low. Lowering that pin is itself an auxiliary falling edge. The stimulus first writes a counter value above the register and lowers the pin with `ext_en_i` set. This checks that the edge is ignored and the count simply goes down. It then writes a value one above the register and steps twice, to see the load of 0xFFFF and the external flag toggling back to 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_RELOAD  = 2'd0,
    TM_CAPTURE = 2'd1,
    TM_UPDOWN  = 2'd2,
    TM_CLKOUT  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_pin_sampler.sv
module tmr_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      prev_q <= 1'b0;
    else if (tick_i) prev_q <= pin_i;
  end

  assign fall_o = tick_i && prev_q && !pin_i;

  AST_NO_BACK_TO_BACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R2
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode_i,
  input  logic         step_i,
  input  logic         up_i,
  input  logic         ext_evt_i,
  input  logic         wr_cnt_i,
  input  logic [W-1:0] wr_cnt_data_i,
  input  logic         wr_cap_i,
  input  logic [W-1:0] wr_cap_data_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o,
  output logic         wrap_o,
  output logic         tog_o
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cap_q, cnt_nxt;
  logic at_top, at_cap, down, ext_reload, ext_capture, count_go;
  logic tog_q;

  assign at_top      = (cnt_q == TOP);
  assign at_cap      = (cnt_q == cap_q);
  assign down        = (mode_i == TM_UPDOWN) && !up_i;
  assign ext_reload  = ext_evt_i && (mode_i == TM_RELOAD);
  assign ext_capture = ext_evt_i && (mode_i == TM_CAPTURE);
  assign count_go    = step_i && !wr_cnt_i && !ext_reload;
  assign wrap_o      = count_go && (down ? at_cap : at_top);

  always_comb begin
    if (down)                                 cnt_nxt = wrap_o ? TOP : cnt_q - ONE;
    else if (wrap_o && mode_i != TM_CAPTURE)  cnt_nxt = cap_q;
    else                                      cnt_nxt = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      tog_q <= 1'b0;
    end else begin
      if (wr_cnt_i)        cnt_q <= wr_cnt_data_i;
      else if (ext_reload) cnt_q <= cap_q;
      else if (count_go)   cnt_q <= cnt_nxt;

      if (wr_cap_i)         cap_q <= wr_cap_data_i;
      else if (ext_capture) cap_q <= cnt_q;

      if (wrap_o && mode_i == TM_CLKOUT) tog_q <= ~tog_q;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign tog_o = tog_q;

  AST_UP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !wr_cnt_i && !ext_evt_i && mode_i == TM_RELOAD && cnt_q == TOP)
      |=> cnt_q == $past(cap_q)); // R3
  AST_DOWN_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !wr_cnt_i && mode_i == TM_UPDOWN && !up_i && cnt_q == cap_q)
      |=> cnt_q == TOP); // R6
  AST_CLKOUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && mode_i == TM_CLKOUT) |=> tog_q != $past(tog_q)); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_i |=> cnt_q == $past(wr_cnt_data_i)); // R10
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tmr_mode_e mode_i,
  input  logic      wrap_i,
  input  logic      ext_evt_i,
  input  logic      tf_clr_i,
  input  logic      exf_clr_i,
  output logic      tf_o,
  output logic      exf_o,
  output logic      irq_o
);
  logic tf_q, exf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tf_q  <= 1'b0;
      exf_q <= 1'b0;
    end else begin
      if (wrap_i && mode_i != TM_CLKOUT) tf_q <= 1'b1;
      else if (tf_clr_i)                 tf_q <= 1'b0;

      if (mode_i == TM_UPDOWN && wrap_i) exf_q <= ~exf_q;
      else if (ext_evt_i)                exf_q <= 1'b1;
      else if (exf_clr_i)                exf_q <= 1'b0;
    end
  end

  assign tf_o  = tf_q;
  assign exf_o = exf_q;
  assign irq_o = tf_q || (exf_q && mode_i != TM_UPDOWN);

  AST_TF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_q && !tf_clr_i) |=> tf_q); // R9
  AST_CLKOUT_NO_TF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tf_q) |-> $past(mode_i) != TM_CLKOUT); // R8
endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         cnt_src_ext_i,
  input  logic         ext_en_i,
  input  logic         dir_en_i,
  input  logic         clkout_en_i,
  input  logic         cap_sel_i,
  input  logic         cnt_pin_i,
  input  logic         aux_pin_i,
  input  logic         wr_cnt_i,
  input  logic [W-1:0] wr_cnt_data_i,
  input  logic         wr_cap_i,
  input  logic [W-1:0] wr_cap_data_i,
  input  logic         tf_clr_i,
  input  logic         exf_clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o,
  output logic         tf_o,
  output logic         exf_o,
  output logic         irq_o,
  output logic         clk_out_o
);
  tmr_mode_e mode;
  logic cnt_fall, aux_fall, step, ext_evt, wrap, tog;

  always_comb begin
    if (clkout_en_i)    mode = TM_CLKOUT;
    else if (dir_en_i)  mode = TM_UPDOWN;
    else if (cap_sel_i) mode = TM_CAPTURE;
    else                mode = TM_RELOAD;
  end

  tmr_pin_sampler u_cnt_pin (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pin_i(cnt_pin_i), .fall_o(cnt_fall));
  tmr_pin_sampler u_aux_pin (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pin_i(aux_pin_i), .fall_o(aux_fall));

  assign step    = run_i && (cnt_src_ext_i ? cnt_fall : tick_i);
  assign ext_evt = aux_fall && ext_en_i && (mode != TM_UPDOWN);

  tmr_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .step_i(step), .up_i(aux_pin_i),
    .ext_evt_i(ext_evt), .wr_cnt_i(wr_cnt_i), .wr_cnt_data_i(wr_cnt_data_i),
    .wr_cap_i(wr_cap_i), .wr_cap_data_i(wr_cap_data_i),
    .cnt_o(cnt_o), .cap_o(cap_o), .wrap_o(wrap), .tog_o(tog));

  tmr_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wrap_i(wrap), .ext_evt_i(ext_evt),
    .tf_clr_i(tf_clr_i), .exf_clr_i(exf_clr_i),
    .tf_o(tf_o), .exf_o(exf_o), .irq_o(irq_o));

  assign clk_out_o = clkout_en_i && tog;

  AST_UPDOWN_EXF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_UPDOWN && !tf_o) |-> !irq_o); // R7
endmodule

// File: tb/tb_updown_reload_timer.sv
module tb_updown_reload_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, run_i = 0, cnt_src_ext_i = 0, ext_en_i = 0, dir_en_i = 0;
  logic clkout_en_i = 0, cap_sel_i = 0, cnt_pin_i = 0, aux_pin_i = 0;
  logic wr_cnt_i = 0, wr_cap_i = 0, tf_clr_i = 0, exf_clr_i = 0;
  logic [15:0] wr_cnt_data_i = '0, wr_cap_data_i = '0;
  logic [15:0] cnt_o, cap_o;
  logic tf_o, exf_o, irq_o, clk_out_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  updown_reload_timer dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic tick(); tick_i = 1; cyc(); tick_i = 0; endtask

  task automatic set_cnt(input logic [15:0] v);
    wr_cnt_i = 1; wr_cnt_data_i = v; cyc(); wr_cnt_i = 0;
  endtask

  task automatic set_cap(input logic [15:0] v);
    wr_cap_i = 1; wr_cap_data_i = v; cyc(); wr_cap_i = 0;
  endtask

  task automatic clr_flags();
    tf_clr_i = 1; exf_clr_i = 1; cyc(); tf_clr_i = 0; exf_clr_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 cnt", cnt_o, 16'h0);
    chk("R1 cap", cap_o, 16'h0);
    chk("R1 tf", {15'b0, tf_o}, 16'h0);
    chk("R1 exf", {15'b0, exf_o}, 16'h0);
    chk("R1 irq", {15'b0, irq_o}, 16'h0);
    chk("R1 clkout", {15'b0, clk_out_o}, 16'h0);
  endtask

  task automatic t_sources();
    set_cnt(16'h0005);
    run_i = 1;
    tick(); tick(); tick();
    chk("R2 timer ticks", cnt_o, 16'h0008);
    run_i = 0; tick();
    chk("R2 run low holds", cnt_o, 16'h0008);
    run_i = 1; cnt_src_ext_i = 1;
    cnt_pin_i = 1; tick();
    chk("R2 pin high no step", cnt_o, 16'h0008);
    cnt_pin_i = 0; tick();
    chk("R2 pin fall steps", cnt_o, 16'h0009);
    tick();
    chk("R2 pin low stays", cnt_o, 16'h0009);
    cnt_pin_i = 1; cyc(); cnt_pin_i = 0; cyc();
    chk("R2 no tick no step", cnt_o, 16'h0009);
    run_i = 0; cnt_src_ext_i = 0;
  endtask

  task automatic t_reload();
    set_cap(16'h1234);
    set_cnt(16'hFFFE);
    run_i = 1; tick(); tick();
    chk("R3 reload value", cnt_o, 16'h1234);
    chk("R3 tf set", {15'b0, tf_o}, 16'h1);
    chk("R9 irq from tf", {15'b0, irq_o}, 16'h1);
    run_i = 0; clr_flags();
    chk("R9 tf cleared", {15'b0, tf_o}, 16'h0);
    set_cnt(16'h0050);
    aux_pin_i = 1; tick(); aux_pin_i = 0; tick();
    chk("R4 disabled edge cnt", cnt_o, 16'h0050);
    chk("R4 disabled edge exf", {15'b0, exf_o}, 16'h0);
    ext_en_i = 1;
    aux_pin_i = 1; tick(); aux_pin_i = 0; tick();
    chk("R4 edge reload", cnt_o, 16'h1234);
    chk("R4 exf set", {15'b0, exf_o}, 16'h1);
    chk("R9 irq from exf", {15'b0, irq_o}, 16'h1);
    ext_en_i = 0;
    set_cnt(16'hFFFF);
    run_i = 1; tf_clr_i = 1; tick(); tf_clr_i = 0; run_i = 0;
    chk("R9 set beats clear", {15'b0, tf_o}, 16'h1);
    clr_flags();
    chk("R9 exf cleared", {15'b0, exf_o}, 16'h0);
    wr_cnt_i = 1; wr_cnt_data_i = 16'h0777; run_i = 1; tick(); wr_cnt_i = 0; run_i = 0;
    chk("R10 write beats step", cnt_o, 16'h0777);
  endtask

  task automatic t_capture();
    cap_sel_i = 1; ext_en_i = 1;
    set_cnt(16'h00AB);
    aux_pin_i = 1; tick(); aux_pin_i = 0; tick();
    chk("R5 captured", cap_o, 16'h00AB);
    chk("R5 cnt kept", cnt_o, 16'h00AB);
    chk("R5 exf set", {15'b0, exf_o}, 16'h1);
    aux_pin_i = 1; tick();
    aux_pin_i = 0; wr_cap_i = 1; wr_cap_data_i = 16'h4321; tick(); wr_cap_i = 0;
    chk("R10 write beats capture", cap_o, 16'h4321);
    clr_flags();
    set_cnt(16'hFFFF);
    run_i = 1; tick(); run_i = 0;
    chk("R5 wrap to zero", cnt_o, 16'h0000);
    chk("R5 tf set", {15'b0, tf_o}, 16'h1);
    clr_flags();
    cap_sel_i = 0; ext_en_i = 0;
  endtask

  task automatic t_updown();
    dir_en_i = 1; ext_en_i = 1;
    set_cap(16'h0010);
    set_cnt(16'hFFFF);
    aux_pin_i = 1; run_i = 1; tick();
    chk("R6 up reload", cnt_o, 16'h0010);
    chk("R6 tf up", {15'b0, tf_o}, 16'h1);
    chk("R7 exf toggled on", {15'b0, exf_o}, 16'h1);
    run_i = 0; tf_clr_i = 1; cyc(); tf_clr_i = 0;
    chk("R7 exf no irq", {15'b0, irq_o}, 16'h0);
    set_cnt(16'h0020);
    aux_pin_i = 0; run_i = 1; tick();
    chk("R7 edge ignored, counts down", cnt_o, 16'h001F);
    chk("R7 edge no exf change", {15'b0, exf_o}, 16'h1);
    run_i = 0;
    set_cnt(16'h0011);
    run_i = 1; tick(); tick(); run_i = 0;
    chk("R6 underflow loads top", cnt_o, 16'hFFFF);
    chk("R6 tf down", {15'b0, tf_o}, 16'h1);
    chk("R7 exf toggled off", {15'b0, exf_o}, 16'h0);
    clr_flags();
    dir_en_i = 0; ext_en_i = 0;
  endtask

  task automatic t_clkout();
    chk("R8 output low when off", {15'b0, clk_out_o}, 16'h0);
    clkout_en_i = 1;
    set_cap(16'hFFFE);
    set_cnt(16'hFFFE);
    run_i = 1; tick(); tick();
    chk("R8 reload", cnt_o, 16'hFFFE);
    chk("R8 output high", {15'b0, clk_out_o}, 16'h1);
    chk("R8 no tf", {15'b0, tf_o}, 16'h0);
    tick(); tick();
    chk("R8 output low", {15'b0, clk_out_o}, 16'h0);
    chk("R8 still no tf", {15'b0, tf_o}, 16'h0);
    run_i = 0; clkout_en_i = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    t_reset();
    t_sources();
    t_reload();
    t_capture();
    t_updown();
    t_clkout();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule